// File: doc/BRIEF.md
# Analog Television Sync Timing Generator

This block produces the complete set of line and field timing strobes for a 525-line or a 625-line analog television raster. It runs from a clock at four times the colour subcarrier frequency. A horizontal counter advances once per clock. A vertical counter advances twice per line, once at the start of the line and once at mid-line, so it counts half-lines. Combinational decoding of the two counters produces the horizontal sync, composite sync, colour burst gate, horizontal blanking and an active-low vertical blanking strobe. Composite sync carries equalizing and serrated broad pulses. A field flag is also produced.

Two static inputs set the operating point. `pal_sel` picks the 625-line timing set, and `interlace` picks interlaced scanning. Change them only while reset is held. A display or overlay pipeline uses the strobes to place pixels and to drive an external video encoder. All outputs except `vblank_n` are active high.

Top module: `tvsync_gen`

## Requirements
- R1: A synchronous active-high `rst` puts both counters at zero and the field flag at 0. In that state the outputs are hsync=1, csync=1, burst=0, hblank=1, vblank_n=0, field=0.
- R2: With pal_sel=0 a line lasts 910 clocks. With pal_sel=1 an ordinary line lasts 1135 clocks. Line length is measured between successive rising edges of hsync.
- R3: hsync is high for the first 68 clocks of each line when pal_sel=0, and for the first 84 clocks when pal_sel=1.
- R4: With pal_sel=1, a line that ends while the half-line count is one of the two highest counts of the field lasts 1137 clocks.
- R5: The half-line count advances at clock 0 and at clock 455 (pal_sel=0) or 568 (pal_sel=1) of each line. It returns to 0 after the last half-line of the field. A field is 525 half-lines (pal_sel=0, interlaced), 526 (pal_sel=0, progressive), 625 (pal_sel=1, interlaced) or 624 (pal_sel=1, progressive).
- R6: Some half-lines carry equalizing pulses. These are counts 6..11 (pal_sel=0) or 5..9 (pal_sel=1), plus every count from the vertical blank start (519 or 620) up to the field end. In a first half-line of these, csync is high for clock < 34 (pal_sel=0) or < 42 (pal_sel=1). In a second half-line of these, csync is high from the mid-line point up to clock 488 (pal_sel=0) or 609 (pal_sel=1).
- R7: Half-line counts 0..5 (pal_sel=0) or 0..4 (pal_sel=1) carry broad pulses. In a first half-line, csync is high for clock < 388 (pal_sel=0) or < 484 (pal_sel=1). In a second half-line, it is high from the mid-line point up to clock 841 (pal_sel=0) or 1049 (pal_sel=1).
- R8: In all other half-lines csync equals hsync.
- R9: burst is high for clocks 76..111 (pal_sel=0) or 100..139 (pal_sel=1). It stays low in every half-line named in R6 or R7.
- R10: hblank is high for clock < 143 or clock >= 888 when pal_sel=0, and for clock < 186 or clock >= 1106 when pal_sel=1.
- R11: vblank_n is low when the half-line count is below 36 or at least 519 (pal_sel=0). For pal_sel=1 the limits are 45 and 620.
- R12: The field flag inverts each time the half-line count returns to 0 while interlace=1. With interlace=0 it stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Four-times-subcarrier clock |
| rst | input | 1 | Synchronous active-high reset |
| pal_sel | input | 1 | 0 selects 525-line timing, 1 selects 625-line timing |
| interlace | input | 1 | 1 selects interlaced scanning |
| hsync | output | 1 | Horizontal sync pulse |
| csync | output | 1 | Composite sync with equalizing and broad pulses |
| burst | output | 1 | Colour burst gate |
| hblank | output | 1 | Horizontal blanking |
| vblank_n | output | 1 | Vertical blanking, low while blanked |
| field | output | 1 | Field flag |

## Verification
Each of the four combinations of standard and scan mode is run from reset through at least one complete field, and interlaced runs cover two fields. The interlaced 525-line run separates fields that start at line start from fields that start at mid-line, where the broad and equalizing shapes flip halves. The two 625-line runs separate the stretched final line from ordinary lines in both field parities. The progressive runs confirm that the field flag holds still and that the field length is even. The vertical blank start and the field length are shortened through top-level parameters so that whole fields fit in the run. All horizontal positions and the sync, equalizing and blanking limits keep their real values.

// File: rtl/tvsync_pkg.sv
`timescale 1ns/1ps
package tvsync_pkg;

    localparam int HCW = 11;
    localparam int VCW = 10;

    typedef logic [HCW-1:0] hcnt_t;
    typedef logic [VCW-1:0] vcnt_t;

    typedef enum logic {
        STD_525 = 1'b0,
        STD_625 = 1'b1
    } tv_std_e;

    typedef enum logic [1:0] {
        VZ_ACTIVE = 2'd0,
        VZ_EQUAL  = 2'd1,
        VZ_BROAD  = 2'd2
    } vzone_e;

    // Horizontal event positions in clock ticks from line start
    typedef struct packed {
        hcnt_t sync_end;
        hcnt_t eq1_end;
        hcnt_t ser1_at;
        hcnt_t mid_at;
        hcnt_t eq2_end;
        hcnt_t ser2_at;
        hcnt_t burst_on;
        hcnt_t burst_off;
        hcnt_t blank_off;
        hcnt_t blank_on;
    } hline_t;

    typedef struct packed {
        logic hsync;
        logic csync;
        logic burst;
        logic hblank;
        logic vblank_n;
    } sync_out_t;

    function automatic hline_t line_plan(tv_std_e s);
        hline_t p;
        if (s == STD_625) begin
            p.sync_end  = hcnt_t'(84);
            p.eq1_end   = hcnt_t'(42);
            p.ser1_at   = hcnt_t'(484);
            p.mid_at    = hcnt_t'(568);
            p.eq2_end   = hcnt_t'(610);
            p.ser2_at   = hcnt_t'(1050);
            p.burst_on  = hcnt_t'(100);
            p.burst_off = hcnt_t'(140);
            p.blank_off = hcnt_t'(186);
            p.blank_on  = hcnt_t'(1106);
        end else begin
            p.sync_end  = hcnt_t'(68);
            p.eq1_end   = hcnt_t'(34);
            p.ser1_at   = hcnt_t'(388);
            p.mid_at    = hcnt_t'(455);
            p.eq2_end   = hcnt_t'(489);
            p.ser2_at   = hcnt_t'(842);
            p.burst_on  = hcnt_t'(76);
            p.burst_off = hcnt_t'(112);
            p.blank_off = hcnt_t'(143);
            p.blank_on  = hcnt_t'(888);
        end
        return p;
    endfunction

    // Final count of a line; the stretched variant exists only for 625 lines
    function automatic hcnt_t line_last(tv_std_e s, logic stretch);
        if (s == STD_625)
            return stretch ? hcnt_t'(1136) : hcnt_t'(1134);
        return hcnt_t'(909);
    endfunction

    function automatic hcnt_t mid_point(tv_std_e s);
        return (s == STD_625) ? hcnt_t'(568) : hcnt_t'(455);
    endfunction

endpackage

// File: rtl/tvsync_hcount.sv
`timescale 1ns/1ps
module tvsync_hcount
    import tvsync_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  tv_std_e std_sel,
    input  logic    stretch,
    output hcnt_t   hcnt,
    output logic    line_end,
    output logic    mid_tick
);

    hcnt_t last_q;
    hcnt_t mid_m1;

    always_comb begin
        last_q   = line_last(std_sel, stretch);
        mid_m1   = mid_point(std_sel) - hcnt_t'(1);
        line_end = (hcnt == last_q);
        mid_tick = (hcnt == mid_m1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            hcnt <= '0;
        else if (line_end)
            hcnt <= '0;
        else
            hcnt <= hcnt + hcnt_t'(1);
    end

endmodule

// File: rtl/tvsync_vcount.sv
`timescale 1ns/1ps
module tvsync_vcount
    import tvsync_pkg::*;
#(
    parameter int FIELD_525I = 525,
    parameter int FIELD_525P = 526,
    parameter int FIELD_625I = 625,
    parameter int FIELD_625P = 624
) (
    input  logic    clk,
    input  logic    rst,
    input  tv_std_e std_sel,
    input  logic    interlace,
    input  logic    step,
    output vcnt_t   vcnt,
    output logic    field,
    output logic    final_line
);

    localparam vcnt_t L525I = vcnt_t'(FIELD_525I - 1);
    localparam vcnt_t L525P = vcnt_t'(FIELD_525P - 1);
    localparam vcnt_t L625I = vcnt_t'(FIELD_625I - 1);
    localparam vcnt_t L625P = vcnt_t'(FIELD_625P - 1);

    vcnt_t top_q;

    always_comb begin
        if (std_sel == STD_625)
            top_q = interlace ? L625I : L625P;
        else
            top_q = interlace ? L525I : L525P;
        final_line = (vcnt >= top_q - vcnt_t'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vcnt  <= '0;
            field <= 1'b0;
        end else if (step) begin
            if (vcnt == top_q) begin
                vcnt <= '0;
                if (interlace)
                    field <= ~field;
            end else begin
                vcnt <= vcnt + vcnt_t'(1);
            end
        end
    end

endmodule

// File: rtl/tvsync_decode.sv
`timescale 1ns/1ps
module tvsync_decode
    import tvsync_pkg::*;
#(
    parameter int VSYNC_END_525 = 6,
    parameter int EQ_END_525    = 12,
    parameter int VB_END_525    = 36,
    parameter int VB_START_525  = 519,
    parameter int VSYNC_END_625 = 5,
    parameter int EQ_END_625    = 10,
    parameter int VB_END_625    = 45,
    parameter int VB_START_625  = 620
) (
    input  tv_std_e   std_sel,
    input  hcnt_t     hcnt,
    input  vcnt_t     vcnt,
    output sync_out_t so
);

    localparam vcnt_t VS525 = vcnt_t'(VSYNC_END_525);
    localparam vcnt_t EQ525 = vcnt_t'(EQ_END_525);
    localparam vcnt_t VE525 = vcnt_t'(VB_END_525);
    localparam vcnt_t VB525 = vcnt_t'(VB_START_525);
    localparam vcnt_t VS625 = vcnt_t'(VSYNC_END_625);
    localparam vcnt_t EQ625 = vcnt_t'(EQ_END_625);
    localparam vcnt_t VE625 = vcnt_t'(VB_END_625);
    localparam vcnt_t VB625 = vcnt_t'(VB_START_625);

    hline_t p;
    vcnt_t  vs_end, eq_end, vb_end, vb_start;
    vzone_e zone;
    logic   first_half;

    always_comb begin
        p = line_plan(std_sel);
        if (std_sel == STD_625) begin
            vs_end = VS625; eq_end = EQ625; vb_end = VE625; vb_start = VB625;
        end else begin
            vs_end = VS525; eq_end = EQ525; vb_end = VE525; vb_start = VB525;
        end
    end

    always_comb begin
        first_half = (hcnt < p.mid_at);
        if (vcnt < vs_end)
            zone = VZ_BROAD;
        else if (vcnt < eq_end || vcnt >= vb_start)
            zone = VZ_EQUAL;
        else
            zone = VZ_ACTIVE;
    end

    always_comb begin
        so.hsync  = (hcnt < p.sync_end);
        so.hblank = (hcnt < p.blank_off) || (hcnt >= p.blank_on);
        so.burst  = (zone == VZ_ACTIVE) && (hcnt >= p.burst_on) && (hcnt < p.burst_off);
        so.vblank_n = !((vcnt < vb_end) || (vcnt >= vb_start));
        unique case (zone)
            VZ_BROAD: so.csync = first_half ? (hcnt < p.ser1_at) : (hcnt < p.ser2_at);
            VZ_EQUAL: so.csync = first_half ? (hcnt < p.eq1_end) : (hcnt < p.eq2_end);
            default:  so.csync = (hcnt < p.sync_end);
        endcase
    end

endmodule

// File: rtl/tvsync_gen.sv
`timescale 1ns/1ps
module tvsync_gen
    import tvsync_pkg::*;
#(
    parameter int VB_START_525 = 519,
    parameter int FIELD_525I   = 525,
    parameter int FIELD_525P   = 526,
    parameter int VB_START_625 = 620,
    parameter int FIELD_625I   = 625,
    parameter int FIELD_625P   = 624
) (
    input  logic clk,
    input  logic rst,
    input  logic pal_sel,
    input  logic interlace,
    output logic hsync,
    output logic csync,
    output logic burst,
    output logic hblank,
    output logic vblank_n,
    output logic field
);

    tv_std_e   std_sel;
    hcnt_t     hcnt;
    vcnt_t     vcnt;
    logic      line_end;
    logic      mid_tick;
    logic      final_line;
    sync_out_t so;

    assign std_sel = pal_sel ? STD_625 : STD_525;

    tvsync_hcount u_h (
        .clk      (clk),
        .rst      (rst),
        .std_sel  (std_sel),
        .stretch  (final_line),
        .hcnt     (hcnt),
        .line_end (line_end),
        .mid_tick (mid_tick)
    );

    tvsync_vcount #(
        .FIELD_525I (FIELD_525I),
        .FIELD_525P (FIELD_525P),
        .FIELD_625I (FIELD_625I),
        .FIELD_625P (FIELD_625P)
    ) u_v (
        .clk        (clk),
        .rst        (rst),
        .std_sel    (std_sel),
        .interlace  (interlace),
        .step       (line_end | mid_tick),
        .vcnt       (vcnt),
        .field      (field),
        .final_line (final_line)
    );

    tvsync_decode #(
        .VB_START_525 (VB_START_525),
        .VB_START_625 (VB_START_625)
    ) u_d (
        .std_sel (std_sel),
        .hcnt    (hcnt),
        .vcnt    (vcnt),
        .so      (so)
    );

    assign hsync    = so.hsync;
    assign csync    = so.csync;
    assign burst    = so.burst;
    assign hblank   = so.hblank;
    assign vblank_n = so.vblank_n;

endmodule

// File: rtl/tvsync_chk.sv
`timescale 1ns/1ps
module tvsync_chk (
    input logic clk,
    input logic rst,
    input logic interlace,
    input logic hsync,
    input logic hblank,
    input logic burst,
    input logic field,
    input logic vblank_n
);

    logic [7:0] hs_run;

    always_ff @(posedge clk) begin
        if (rst)
            hs_run <= '0;
        else if (hsync)
            hs_run <= (hs_run == 8'hFF) ? hs_run : hs_run + 8'd1;
        else
            hs_run <= '0;
    end

    // R3
    hsync_width_chk: assert property (@(posedge clk) disable iff (rst)
        hs_run <= 8'd84);

    // R10
    hsync_in_blank_chk: assert property (@(posedge clk) disable iff (rst)
        hsync |-> hblank);

    // R9
    burst_in_blank_chk: assert property (@(posedge clk) disable iff (rst)
        burst |-> (hblank && !hsync));

    // R12
    field_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !interlace |=> $stable(field));

    // R12
    field_flip_in_vblank_chk: assert property (@(posedge clk) disable iff (rst)
        (field != $past(field)) |-> !vblank_n);

endmodule

bind tvsync_gen tvsync_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .interlace (interlace),
    .hsync     (hsync),
    .hblank    (hblank),
    .burst     (burst),
    .field     (field),
    .vblank_n  (vblank_n)
);

// File: tb/sim_tvsync_gen.sv
`timescale 1ns/1ps
module sim_tvsync_gen;

    // Shortened fields so whole fields fit in the run
    localparam int N_VB = 40;
    localparam int N_FI = 45;
    localparam int N_FP = 46;
    localparam int P_VB = 50;
    localparam int P_FI = 55;
    localparam int P_FP = 54;

    typedef struct {
        bit hs, cs, bu, hb, vb, fd;
        bit rst_item;
        int zone;
        int period;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pal_sel = 1'b0;
    logic interlace = 1'b0;
    logic hsync, csync, burst, hblank, vblank_n, field;

    int checks = 0;
    int errors = 0;
    item_t q[$];

    int mh, mv, mf;
    bit m_pal, m_il;

    always #2 clk = ~clk;

    tvsync_gen #(
        .VB_START_525 (N_VB), .FIELD_525I (N_FI), .FIELD_525P (N_FP),
        .VB_START_625 (P_VB), .FIELD_625I (P_FI), .FIELD_625P (P_FP)
    ) u0 (
        .clk (clk), .rst (rst), .pal_sel (pal_sel), .interlace (interlace),
        .hsync (hsync), .csync (csync), .burst (burst), .hblank (hblank),
        .vblank_n (vblank_n), .field (field)
    );

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic item_t predict(bit pal, int vbs, int h, int v, int f);
        item_t e;
        int se   = pal ? 84 : 68;
        int eq1  = pal ? 42 : 34;
        int ser1 = pal ? 484 : 388;
        int mid  = pal ? 568 : 455;
        int eq2e = pal ? 610 : 489;
        int ser2 = pal ? 1050 : 842;
        int bon  = pal ? 100 : 76;
        int boff = pal ? 140 : 112;
        int blof = pal ? 186 : 143;
        int blon = pal ? 1106 : 888;
        int vse  = pal ? 5 : 6;
        int vee  = pal ? 10 : 12;
        int vbe  = pal ? 45 : 36;
        bit first = (h < mid);
        if (v < vse) e.zone = 2;
        else if (v < vee || v >= vbs) e.zone = 1;
        else e.zone = 0;
        if (e.zone == 2) e.cs = first ? (h < ser1) : (h < ser2);
        else if (e.zone == 1) e.cs = first ? (h < eq1) : (h < eq2e);
        else e.cs = (h < se);
        e.hs = (h < se);
        e.bu = (h >= bon) && (h < boff) && (e.zone == 0);
        e.hb = (h < blof) || (h >= blon);
        e.vb = !((v < vbe) || (v >= vbs));
        e.fd = f[0];
        e.rst_item = 1'b0;
        e.period = 0;
        return e;
    endfunction

    task automatic push_now(bit is_rst, int period);
        item_t e = predict(m_pal, m_pal ? P_VB : N_VB, mh, mv, mf);
        e.rst_item = is_rst;
        e.period = period;
        q.push_back(e);
    endtask

    task automatic step_model(output int period);
        int wrap = m_pal ? (m_il ? P_FI : P_FP) : (m_il ? N_FI : N_FP);
        int last = m_pal ? ((mv >= wrap - 2) ? 1136 : 1134) : 909;
        int mid  = m_pal ? 568 : 455;
        bit adv  = (mh == last) || (mh == mid - 1);
        period = 0;
        if (mh == last) begin
            period = last + 1;
            mh = 0;
        end else begin
            mh++;
        end
        if (adv) begin
            if (mv == wrap - 1) begin
                mv = 0;
                if (m_il) mf ^= 1;
            end else begin
                mv++;
            end
        end
    endtask

    task automatic run_mode(bit pal, bit il, int cycles);
        int per;
        @(negedge clk);
        rst = 1'b1;
        pal_sel = pal;
        interlace = il;
        m_pal = pal;
        m_il = il;
        repeat (3) @(posedge clk);
        #1;
        mh = 0; mv = 0; mf = 0;
        push_now(1'b1, 0);   // R1 reset state
        rst = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk);
            #1;
            step_model(per);
            push_now(1'b0, per);
        end
    endtask

    // Monitor: pops expected items and compares away from the active edge
    bit prev_hs;
    int hcyc;
    always @(negedge clk) begin
        item_t e;
        string ct;
        if (q.size() != 0) begin
            e = q.pop_front();
            ct = (e.zone == 2) ? "R7" : (e.zone == 1) ? "R6" : "R8";
            chk(e.rst_item ? "R1" : "R3", "hsync", int'(hsync), int'(e.hs));
            chk(e.rst_item ? "R1" : ct, "csync", int'(csync), int'(e.cs));
            chk(e.rst_item ? "R1" : "R9", "burst", int'(burst), int'(e.bu));
            chk(e.rst_item ? "R1" : "R10", "hblank", int'(hblank), int'(e.hb));
            chk(e.rst_item ? "R1" : "R11 R5", "vblank_n", int'(vblank_n), int'(e.vb));
            chk(e.rst_item ? "R1" : "R12", "field", int'(field), int'(e.fd));
            if (e.rst_item) begin
                hcyc = 1;
                prev_hs = hsync;
            end else begin
                if (hsync && !prev_hs) begin
                    chk((e.period == 1137) ? "R4" : "R2", "line length", hcyc, e.period);
                    hcyc = 1;
                end else begin
                    hcyc++;
                end
                prev_hs = hsync;
            end
        end
    end

    initial begin
        run_mode(1'b0, 1'b1, 42000);   // 525 interlaced, two fields
        run_mode(1'b0, 1'b0, 23000);   // 525 progressive
        run_mode(1'b1, 1'b1, 64000);   // 625 interlaced, two fields
        run_mode(1'b1, 1'b0, 33000);   // 625 progressive
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (198000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R1..: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule